// File: doc/BRIEF.md
# Multi-Sector Authentication Access Gate

This block sits between the command decoder of a contactless memory card and its non-volatile array. The array is seen as 16 sectors of 4 blocks, each block 16 bytes. Blocks 0 to 2 of a sector carry data and block 3 is the sector trailer that holds that sector's keys and access bytes. For every read, write or value request the gate returns a single grant-or-deny verdict. The verdict depends on the authentication context recorded for the current transaction and on the operating level.

The gate keeps a per-sector descriptor table. For each sector and each key type (A or B) the table holds a small key-identifier code. Two sectors that hold the same identifier for a type are treated as secured by the same key value. On a successful authentication the gate records the authenticated sector, the key type and the identifier that the table holds for them. This record replaces any earlier one and starts a new transaction. A failed authentication or an explicit reset of authentication removes the context.

At the AES level, one authentication opens every sector whose identifier for the authenticated key type equals the recorded one. No further authentication is needed for those sectors. At the lower levels only the sector that was last authenticated is open. The manufacturer block (sector 0, block 0) never accepts a modifying operation. Key storage, cryptography and the decoding of access bits are handled elsewhere.

Top module: `sector_auth_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `resp_valid` and `resp_grant` are 0, the context is empty, and every descriptor identifier is 0.
- R2: A request with `req_valid` high at an edge is answered at that edge: `resp_valid` is 1 in the following cycle and 0 in any cycle that follows no request. `resp_grant` is never 1 while `resp_valid` is 0.
- R3: While no successful authentication has been recorded since reset or since the last clear, every request is denied.
- R4: A write (`req_op` 2'b01) or a value operation (`req_op` 2'b10) to sector 0, block 0 is always denied. A read (`req_op` 2'b00) of that block, and any operation on other blocks including trailers, follows the remaining rules.
- R5: The reserved operation code 2'b11 is always denied.
- R6: When `sec_level` is not 2'b11, a request is granted only if its sector equals the recorded authenticated sector.
- R7: When `sec_level` is 2'b11, a request is granted when the target sector's current identifier for the recorded key type equals the recorded identifier, whether or not it is the authenticated sector.
- R8: `auth_ok` records the sector `auth_sector`, the key type `auth_key_b` (0 = A, 1 = B) and the table identifier for that pair as it stands at that edge. The record replaces any earlier context.
- R9: `auth_fail` or `auth_clear` empties the context at that edge and takes priority over a simultaneous `auth_ok`.
- R10: A descriptor write with `tbl_wr_en` changes the identifier used by requests from the next cycle. It does not alter an identifier already recorded in the context.
- R11: A request presented in the same cycle as an authentication event or a descriptor write is judged on the context and table as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_level | input | 2 | Operating level; 2'b11 selects AES-level key sharing |
| tbl_wr_en | input | 1 | Write one descriptor identifier |
| tbl_wr_sector | input | 4 | Sector of the descriptor write |
| tbl_wr_key_b | input | 1 | Key type of the descriptor write (0 = A, 1 = B) |
| tbl_wr_key_id | input | 4 | New key-identifier code |
| auth_ok | input | 1 | Successful authentication pulse |
| auth_fail | input | 1 | Failed authentication pulse |
| auth_clear | input | 1 | Reset-authentication command pulse |
| auth_sector | input | 4 | Sector named by the authentication |
| auth_key_b | input | 1 | Key type used by the authentication |
| req_valid | input | 1 | Access request present |
| req_sector | input | 4 | Target sector |
| req_block | input | 2 | Target block inside the sector |
| req_op | input | 2 | 00 read, 01 write, 10 value, 11 reserved |
| resp_valid | output | 1 | Verdict present for the previous cycle's request |
| resp_grant | output | 1 | 1 = access may proceed, 0 = denied |

## Verification
Directed sequences first set up a table with two sectors that share an identifier, a sector with a different one, and separate codes for type B. They then run each request at both kinds of level. This separates sharing by key identity from sharing by sector number, and key type A from type B. Single-cycle overlaps follow: a request together with a clear, authentication together with a failure, and a table write followed by requests to the rewritten sector and to the authenticated one. These show whether ordering and priority are right and whether the recorded identifier is a snapshot or a live lookup. A long random run with a narrow identifier range, so that matches happen often, mixes all inputs. A behavioural model checks every cycle against the design.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the sector authentication gate.
// Assumes a 2-bit operation code and a 2-bit level code at the block edge.
package sag_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_VALUE = 2'b10,
        OP_RSVD  = 2'b11
    } access_op_e;

    // Level code that enables key sharing across sectors
    localparam logic [1:0] LVL_AES = 2'b11;
endpackage

// File: rtl/sag_key_table.sv
`timescale 1ns/1ps
// Per-sector key descriptor table: one identifier code for key A and one for
// key B in every sector. One write port, two combinational read ports.
// Assumes NUM_SECTORS is a power of two so every sector index is in range.
module sag_key_table #(
    parameter int NUM_SECTORS = 16,
    parameter int KEY_ID_W    = 4,
    localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEC_W-1:0]    wr_sector,
    input  logic                wr_key_b,
    input  logic [KEY_ID_W-1:0] wr_key_id,
    input  logic [SEC_W-1:0]    rd_a_sector,
    input  logic                rd_a_key_b,
    output logic [KEY_ID_W-1:0] rd_a_key_id,
    input  logic [SEC_W-1:0]    rd_b_sector,
    input  logic                rd_b_key_b,
    output logic [KEY_ID_W-1:0] rd_b_key_id
);
    logic [KEY_ID_W-1:0] id_a_q [NUM_SECTORS];
    logic [KEY_ID_W-1:0] id_b_q [NUM_SECTORS];

    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sector
        // Hold and update the two identifiers of sector g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_a_q[g] <= '0;
                id_b_q[g] <= '0;
            end else if (wr_en && (wr_sector == SEC_W'(g))) begin
                if (wr_key_b) id_b_q[g] <= wr_key_id;
                else          id_a_q[g] <= wr_key_id;
            end
        end
    end

    // Read port A: used to capture the identifier at authentication
    always_comb rd_a_key_id = rd_a_key_b ? id_b_q[rd_a_sector] : id_a_q[rd_a_sector];
    // Read port B: used to look up the target sector of a request
    always_comb rd_b_key_id = rd_b_key_b ? id_b_q[rd_b_sector] : id_a_q[rd_b_sector];

    AST_TBL_WRITE_A_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_key_b) |=> (id_a_q[$past(wr_sector)] == $past(wr_key_id))); // R10
    AST_TBL_WRITE_B_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_key_b) |=> (id_b_q[$past(wr_sector)] == $past(wr_key_id))); // R10
endmodule

// File: rtl/sag_auth_context.sv
`timescale 1ns/1ps
// Authentication context of the current transaction: valid flag, sector,
// key type and the identifier captured from the table at authentication.
// Assumes fail/clear pulses take priority over a simultaneous success.
module sag_auth_context #(
    parameter int NUM_SECTORS = 16,
    parameter int KEY_ID_W    = 4,
    localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                auth_ok,
    input  logic                auth_fail,
    input  logic                auth_clear,
    input  logic [SEC_W-1:0]    auth_sector,
    input  logic                auth_key_b,
    input  logic [KEY_ID_W-1:0] auth_key_id,
    output logic                ctx_valid,
    output logic [SEC_W-1:0]    ctx_sector,
    output logic                ctx_key_b,
    output logic [KEY_ID_W-1:0] ctx_key_id
);
    logic drop;

    // A failure or reset-authentication command ends the transaction
    always_comb drop = auth_fail || auth_clear;

    // Record or clear the context on authentication events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_valid  <= 1'b0;
            ctx_sector <= '0;
            ctx_key_b  <= 1'b0;
            ctx_key_id <= '0;
        end else if (drop) begin
            ctx_valid  <= 1'b0;
        end else if (auth_ok) begin
            ctx_valid  <= 1'b1;
            ctx_sector <= auth_sector;
            ctx_key_b  <= auth_key_b;
            ctx_key_id <= auth_key_id;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_fail || auth_clear) |=> !ctx_valid); // R9
    AST_OK_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_ok && !auth_fail && !auth_clear) |=>
            (ctx_valid && ctx_sector == $past(auth_sector) && ctx_key_b == $past(auth_key_b))); // R8
    AST_CTX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!auth_ok && !auth_fail && !auth_clear) |=> $stable(ctx_key_id)); // R10
endmodule

// File: rtl/sag_access_decider.sv
`timescale 1ns/1ps
// Turns one access request into a registered grant/deny verdict.
// Assumes tgt_key_id is the table identifier of the request's sector for the
// recorded key type, so an identifier match also implies a key type match.
module sag_access_decider
    import sag_pkg::*;
#(
    parameter int NUM_SECTORS       = 16,
    parameter int BLOCKS_PER_SECTOR = 4,
    parameter int KEY_ID_W          = 4,
    localparam int SEC_W            = $clog2(NUM_SECTORS),
    localparam int BLK_W            = $clog2(BLOCKS_PER_SECTOR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          sec_level,
    input  logic                req_valid,
    input  logic [SEC_W-1:0]    req_sector,
    input  logic [BLK_W-1:0]    req_block,
    input  logic [1:0]          req_op,
    input  logic                ctx_valid,
    input  logic [SEC_W-1:0]    ctx_sector,
    input  logic [KEY_ID_W-1:0] ctx_key_id,
    input  logic [KEY_ID_W-1:0] tgt_key_id,
    output logic                resp_valid,
    output logic                resp_grant
);
    logic is_mfg_block;
    logic modifies;
    logic op_known;
    logic scope_ok;
    logic grant_d;

    // Classify the request
    always_comb begin
        is_mfg_block = (req_sector == '0) && (req_block == '0);
        modifies     = (req_op == OP_WRITE) || (req_op == OP_VALUE);
        op_known     = (req_op != OP_RSVD);
    end

    // Sector reach: shared key identity at the AES level, same sector otherwise
    always_comb begin
        if (sec_level == LVL_AES) scope_ok = (tgt_key_id == ctx_key_id);
        else                      scope_ok = (req_sector == ctx_sector);
    end

    // Combine all conditions into the next verdict
    always_comb grant_d = req_valid && ctx_valid && op_known
                          && !(is_mfg_block && modifies) && scope_ok;

    // Register the verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_grant <= grant_d;
        end
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R2
    AST_NO_GRANT_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_grant); // R2
    AST_NO_CTX_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctx_valid) |=> !resp_grant); // R3
    AST_MFG_BLOCK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sector == '0 && req_block == '0
         && (req_op == OP_WRITE || req_op == OP_VALUE)) |=> !resp_grant); // R4
    AST_RSVD_OP_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RSVD) |=> !resp_grant); // R5
    AST_LOW_LEVEL_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_level != LVL_AES && req_sector != ctx_sector) |=> !resp_grant); // R6
endmodule

// File: rtl/sector_auth_gate.sv
`timescale 1ns/1ps
// Top of the multi-sector authentication access gate. Connects the key
// descriptor table, the transaction context and the verdict logic.
// Assumes at most one request per cycle and one-cycle event pulses.
module sector_auth_gate #(
    parameter int NUM_SECTORS       = 16,
    parameter int BLOCKS_PER_SECTOR = 4,
    parameter int KEY_ID_W          = 4,
    localparam int SEC_W            = $clog2(NUM_SECTORS),
    localparam int BLK_W            = $clog2(BLOCKS_PER_SECTOR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          sec_level,
    input  logic                tbl_wr_en,
    input  logic [SEC_W-1:0]    tbl_wr_sector,
    input  logic                tbl_wr_key_b,
    input  logic [KEY_ID_W-1:0] tbl_wr_key_id,
    input  logic                auth_ok,
    input  logic                auth_fail,
    input  logic                auth_clear,
    input  logic [SEC_W-1:0]    auth_sector,
    input  logic                auth_key_b,
    input  logic                req_valid,
    input  logic [SEC_W-1:0]    req_sector,
    input  logic [BLK_W-1:0]    req_block,
    input  logic [1:0]          req_op,
    output logic                resp_valid,
    output logic                resp_grant
);
    logic [KEY_ID_W-1:0] auth_key_id;
    logic [KEY_ID_W-1:0] tgt_key_id;
    logic                ctx_valid;
    logic [SEC_W-1:0]    ctx_sector;
    logic                ctx_key_b;
    logic [KEY_ID_W-1:0] ctx_key_id;

    sag_key_table #(
        .NUM_SECTORS (NUM_SECTORS),
        .KEY_ID_W    (KEY_ID_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tbl_wr_en),
        .wr_sector   (tbl_wr_sector),
        .wr_key_b    (tbl_wr_key_b),
        .wr_key_id   (tbl_wr_key_id),
        .rd_a_sector (auth_sector),
        .rd_a_key_b  (auth_key_b),
        .rd_a_key_id (auth_key_id),
        .rd_b_sector (req_sector),
        .rd_b_key_b  (ctx_key_b),
        .rd_b_key_id (tgt_key_id)
    );

    sag_auth_context #(
        .NUM_SECTORS (NUM_SECTORS),
        .KEY_ID_W    (KEY_ID_W)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .auth_ok     (auth_ok),
        .auth_fail   (auth_fail),
        .auth_clear  (auth_clear),
        .auth_sector (auth_sector),
        .auth_key_b  (auth_key_b),
        .auth_key_id (auth_key_id),
        .ctx_valid   (ctx_valid),
        .ctx_sector  (ctx_sector),
        .ctx_key_b   (ctx_key_b),
        .ctx_key_id  (ctx_key_id)
    );

    sag_access_decider #(
        .NUM_SECTORS       (NUM_SECTORS),
        .BLOCKS_PER_SECTOR (BLOCKS_PER_SECTOR),
        .KEY_ID_W          (KEY_ID_W)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_level  (sec_level),
        .req_valid  (req_valid),
        .req_sector (req_sector),
        .req_block  (req_block),
        .req_op     (req_op),
        .ctx_valid  (ctx_valid),
        .ctx_sector (ctx_sector),
        .ctx_key_id (ctx_key_id),
        .tgt_key_id (tgt_key_id),
        .resp_valid (resp_valid),
        .resp_grant (resp_grant)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && !resp_grant)); // R1
endmodule

// File: tb/sector_auth_gate_tb.sv
`timescale 1ns/1ps
module sector_auth_gate_tb;
    localparam int NS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sec_level = 2'd0;
    logic       tbl_wr_en, tbl_wr_key_b, auth_ok, auth_fail, auth_clear, auth_key_b, req_valid;
    logic [3:0] tbl_wr_sector, tbl_wr_key_id, auth_sector, req_sector;
    logic [1:0] req_block, req_op;
    logic       resp_valid, resp_grant;

    always #2.5 clk = ~clk;

    sector_auth_gate u_dut (
        .clk(clk), .rst_n(rst_n), .sec_level(sec_level),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_sector(tbl_wr_sector),
        .tbl_wr_key_b(tbl_wr_key_b), .tbl_wr_key_id(tbl_wr_key_id),
        .auth_ok(auth_ok), .auth_fail(auth_fail), .auth_clear(auth_clear),
        .auth_sector(auth_sector), .auth_key_b(auth_key_b),
        .req_valid(req_valid), .req_sector(req_sector), .req_block(req_block),
        .req_op(req_op), .resp_valid(resp_valid), .resp_grant(resp_grant)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string phase = "R1";

    // Behavioural reference state
    int    tbl [NS][2];
    bit    m_valid;
    int    m_sector, m_type, m_id;
    bit    exp_v, exp_g;
    string exp_tag;

    function automatic void model_reset();
        for (int s = 0; s < NS; s++) begin
            tbl[s][0] = 0;
            tbl[s][1] = 0;
        end
        m_valid = 0; m_sector = 0; m_type = 0; m_id = 0;
    endfunction

    function automatic void clear_inputs();
        tbl_wr_en = 0; tbl_wr_sector = 0; tbl_wr_key_b = 0; tbl_wr_key_id = 0;
        auth_ok = 0; auth_fail = 0; auth_clear = 0; auth_sector = 0; auth_key_b = 0;
        req_valid = 0; req_sector = 0; req_block = 0; req_op = 0;
    endfunction

    // Expected verdict from the current model state, then advance the model
    task automatic apply();
        int rs;
        rs = int'(req_sector);
        exp_v = req_valid;
        exp_g = 0;
        if (!req_valid)                                    exp_tag = "R2";
        else if (req_op == 2'b11)                          exp_tag = "R5";
        else if (rs == 0 && req_block == 0 && (req_op == 2'b01 || req_op == 2'b10)) exp_tag = "R4";
        else if (!m_valid)                                 exp_tag = "R3";
        else if (sec_level == 2'b11) begin
            exp_tag = "R7";
            exp_g = (tbl[rs][m_type] == m_id);
        end else begin
            exp_tag = "R6";
            exp_g = (rs == m_sector);
        end
        if (auth_fail || auth_clear) m_valid = 0;
        else if (auth_ok) begin
            m_valid  = 1;
            m_sector = int'(auth_sector);
            m_type   = int'(auth_key_b);
            m_id     = tbl[m_sector][m_type];
        end
        if (tbl_wr_en) tbl[int'(tbl_wr_sector)][int'(tbl_wr_key_b)] = int'(tbl_wr_key_id);
        @(negedge clk);
        vectors++;
        if (resp_valid !== exp_v || resp_grant !== exp_g) begin
            miscompares++;
            $display("FAIL %s (rule %s): valid/grant = %0b/%0b, expected %0b/%0b",
                     phase, exp_tag, resp_valid, resp_grant, exp_v, exp_g);
        end
    endtask

    task automatic do_req(input int s, input int b, input int op);
        clear_inputs();
        req_valid = 1; req_sector = 4'(s); req_block = 2'(b); req_op = 2'(op);
        apply();
    endtask

    task automatic do_auth(input int s, input int t);
        clear_inputs();
        auth_ok = 1; auth_sector = 4'(s); auth_key_b = t[0];
        apply();
    endtask

    task automatic tbl_write(input int s, input int t, input int id);
        clear_inputs();
        tbl_wr_en = 1; tbl_wr_sector = 4'(s); tbl_wr_key_b = t[0]; tbl_wr_key_id = 4'(id);
        apply();
    endtask

    initial begin
        clear_inputs();
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs quiet after reset
        vectors++;
        if (resp_valid !== 1'b0 || resp_grant !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: valid/grant = %0b/%0b, expected 0/0", resp_valid, resp_grant);
        end
        rst_n = 1;

        phase = "R3";
        do_req(3, 1, 0);
        do_req(0, 2, 1);
        sec_level = 2'b11;
        do_req(5, 0, 0);

        phase = "R10";
        for (int s = 0; s < NS; s++) begin
            tbl_write(s, 0, s % 4);
            tbl_write(s, 1, 8 + (s % 2));
        end

        phase = "R8";
        sec_level = 2'b01;
        do_auth(5, 0);
        do_req(5, 2, 0);
        phase = "R6";
        do_req(6, 0, 0);
        do_req(9, 1, 1);
        sec_level = 2'b10;
        do_req(5, 1, 2);
        do_req(1, 1, 2);

        phase = "R7";
        sec_level = 2'b11;
        do_req(9, 1, 1);
        do_req(13, 0, 2);
        do_req(6, 0, 0);
        do_auth(6, 1);
        do_req(4, 2, 0);
        do_req(5, 2, 0);
        do_req(6, 3, 1);

        phase = "R4";
        sec_level = 2'b01;
        do_auth(0, 0);
        do_req(0, 0, 1);
        do_req(0, 0, 2);
        do_req(0, 0, 0);
        do_req(0, 1, 1);
        do_req(0, 3, 1);
        sec_level = 2'b11;
        do_req(0, 0, 1);
        do_req(4, 0, 1);

        phase = "R5";
        do_req(0, 1, 3);
        do_req(4, 2, 3);

        phase = "R10";
        tbl_write(8, 0, 5);
        do_req(8, 0, 0);
        clear_inputs();
        tbl_wr_en = 1; tbl_wr_sector = 4'd12; tbl_wr_key_id = 4'd7;
        req_valid = 1; req_sector = 4'd12; req_op = 2'b00;
        apply();
        do_req(12, 0, 0);
        tbl_write(0, 0, 6);
        do_req(0, 1, 0);
        do_req(4, 1, 0);

        phase = "R11";
        clear_inputs();
        auth_clear = 1; req_valid = 1; req_sector = 4'd4; req_block = 2'd1;
        apply();
        do_req(4, 1, 0);
        clear_inputs();
        auth_ok = 1; auth_sector = 4'd2; req_valid = 1; req_sector = 4'd2; req_block = 2'd1;
        apply();
        do_req(2, 1, 0);

        phase = "R9";
        do_auth(4, 0);
        do_req(4, 1, 1);
        clear_inputs(); auth_fail = 1; apply();
        do_req(4, 1, 1);
        clear_inputs(); auth_ok = 1; auth_fail = 1; auth_sector = 4'd4; apply();
        do_req(4, 1, 1);
        clear_inputs(); auth_ok = 1; auth_clear = 1; auth_sector = 4'd4; apply();
        do_req(4, 1, 1);

        phase = "random R2 R6 R7 R8 R11";
        for (int i = 0; i < 3000; i++) begin
            clear_inputs();
            case ($urandom_range(0, 3))
                0: sec_level = 2'b00;
                1: sec_level = 2'b01;
                2: sec_level = 2'b10;
                default: sec_level = 2'b11;
            endcase
            req_valid     = ($urandom_range(0, 3) != 0);
            req_sector    = 4'($urandom_range(0, 15));
            req_block     = 2'($urandom_range(0, 3));
            req_op        = 2'($urandom_range(0, 3));
            auth_ok       = ($urandom_range(0, 7) == 0);
            auth_sector   = 4'($urandom_range(0, 15));
            auth_key_b    = 1'($urandom_range(0, 1));
            auth_fail     = ($urandom_range(0, 40) == 0);
            auth_clear    = ($urandom_range(0, 40) == 0);
            tbl_wr_en     = ($urandom_range(0, 5) == 0);
            tbl_wr_sector = 4'($urandom_range(0, 15));
            tbl_wr_key_b  = 1'($urandom_range(0, 1));
            tbl_wr_key_id = 4'($urandom_range(0, 3));
            apply();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule